// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block sits between a processor read port and a slow on-chip flash array that also contains a small one-time-programmable (OTP) region. Each read is accepted on a valid/ready request channel. The block then holds the channel stalled for a number of clock cycles that software has programmed. After the stall it returns the array word on a response channel. A flash read whose page tag matches the page of the previous tracked flash read is timed with a short page count. Any other flash read is timed with a longer random count. OTP reads always use a dedicated count and never get the page shortcut.

Two wait registers sit on a plain write/readback bus. The request channel follows valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While a stall is running, `req_ready` is low, and a request held valid during that time waits. The response channel has no back-pressure. `rsp_valid` is a one-cycle pulse that the consumer must take, and `rsp_data` stays stable until the next accepted request. The array behind the controller is modelled as a synchronous memory whose content is computed from the address.

Top module: `flash_wait_ctrl`

## Requirements
- R1: After reset, the bank wait register reads 0x0F0F and the OTP wait register reads 0x001F, which are all wait fields at their maximum.
- R2: `cfg_sel`=0 addresses the bank register: random count in bits [3:0], page count in bits [11:8]. `cfg_sel`=1 addresses the OTP register: OTP count in bits [4:0]. Every other bit reads as zero, even after 0xFFFF is written.
- R3: A read with `req_otp`=1 is always timed with the OTP count, even when its address matches the tracked page.
- R4: With a wait count N>0, `req_ready` is low for the N cycles after the accepting edge. On cycle N+1, `rsp_valid` is high for one cycle together with `req_ready`.
- R5: With a wait count of 0, `rsp_valid` rises in the cycle right after acceptance and `req_ready` never drops.
- R6: A flash read whose address bits [11:7] equal those of the last tracked flash read uses the page count. Any other flash read uses the random count.
- R7: The page tracker is cleared by reset, by any accepted OTP read and by any wait-register write, so the next flash read is random.
- R8: A request held valid during a stall is accepted on the edge that ends the response cycle of the access in progress, and is then timed normally.
- R9: The returned word is the low 16 bits of (address × 0x9E37) XOR 0x5A5A for flash. For OTP it is that value XOR 0xFFFF.
- R10: When a register write and a request acceptance fall on the same edge, the accepted read uses the wait values from before the write, and the tracker ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_otp | input | 1 | Request targets the OTP region |
| req_addr | input | 12 | Word address of the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Word read from the array |
| cfg_wr | input | 1 | Wait-register write strobe |
| cfg_sel | input | 1 | 0 = bank register, 1 = OTP register |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Readback of the selected register |

## Verification
A register write and a request acceptance can land on the same clock edge. The write changes the counts and clears the page tracker, while the acceptance picks a count and loads the tracker. A directed case first loads the tracker with a read on one page. On a single falling edge it then drives both `cfg_wr` and `req_valid` for that same page. The bench judges the result by the measured latency, which must match the old page count. It also checks that the next read on that page runs at the new random count. A second overlap, a request held valid while a stall is running, is provoked in randomly mixed back-to-back pairs and judged by the exact spacing of the two responses.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 16;
  localparam int PAGE_OFS_W = 7;
  localparam int CFG_W      = 16;
  localparam int RAND_W     = 4;
  localparam int PGW_W      = 4;
  localparam int OTPW_W     = 5;
  localparam int RAND_LSB   = 0;
  localparam int PGW_LSB    = 8;
  localparam int OTPW_LSB   = 0;
  localparam int CNT_W      = (OTPW_W > RAND_W) ?
                              ((OTPW_W > PGW_W) ? OTPW_W : PGW_W) :
                              ((RAND_W > PGW_W) ? RAND_W : PGW_W);

  typedef enum logic {SEL_BANK = 1'b0, SEL_OTP = 1'b1} cfg_sel_e;

  // Content of the modelled array, derived from the address.
  function automatic logic [DATA_W-1:0] fws_word(logic [ADDR_W-1:0] a, logic otp);
    logic [31:0] prod;
    prod = 32'(a) * 32'h0000_9E37;
    return prod[DATA_W-1:0] ^ DATA_W'(16'h5A5A) ^ {DATA_W{otp}};
  endfunction
endpackage

// File: rtl/fws_cfg_regs.sv
module fws_cfg_regs
  import fws_pkg::*;
#(
  parameter int P_RAND_W = RAND_W,
  parameter int P_PGW_W  = PGW_W,
  parameter int P_OTPW_W = OTPW_W,
  parameter int P_CFG_W  = CFG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_sel,
  input  logic [P_CFG_W-1:0]  cfg_wdata,
  output logic [P_RAND_W-1:0] rand_w,
  output logic [P_PGW_W-1:0]  page_w,
  output logic [P_OTPW_W-1:0] otp_w,
  output logic [P_CFG_W-1:0]  cfg_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rand_w <= '1;
      page_w <= '1;
      otp_w  <= '1;
    end else if (cfg_wr) begin
      if (cfg_sel == SEL_BANK) begin
        rand_w <= cfg_wdata[RAND_LSB +: P_RAND_W];
        page_w <= cfg_wdata[PGW_LSB +: P_PGW_W];
      end else begin
        otp_w  <= cfg_wdata[OTPW_LSB +: P_OTPW_W];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel == SEL_BANK) begin
      cfg_rdata[RAND_LSB +: P_RAND_W] = rand_w;
      cfg_rdata[PGW_LSB +: P_PGW_W]   = page_w;
    end else begin
      cfg_rdata[OTPW_LSB +: P_OTPW_W] = otp_w;
    end
  end
endmodule

// File: rtl/fws_page_track.sv
module fws_page_track #(
  parameter int P_ADDR_W = 12,
  parameter int P_OFS_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                otp,
  input  logic [P_ADDR_W-1:0] addr,
  input  logic                clear,
  output logic                hit,
  output logic                valid
);
  localparam int TAG_W = P_ADDR_W - P_OFS_W;

  logic [TAG_W-1:0] last_tag;
  logic [TAG_W-1:0] cur_tag;

  assign cur_tag = addr[P_ADDR_W-1:P_OFS_W];
  assign hit     = valid && !otp && (cur_tag == last_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      last_tag <= '0;
    end else if (clear) begin
      valid    <= 1'b0;
    end else if (accept) begin
      if (otp) begin
        valid    <= 1'b0;
      end else begin
        valid    <= 1'b1;
        last_tag <= cur_tag;
      end
    end
  end
endmodule

// File: rtl/fws_timer.sv
module fws_timer #(
  parameter int P_CNT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [P_CNT_W-1:0] wait_n,
  output logic               busy,
  output logic               done
);
  logic [P_CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (wait_n == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= wait_n;
        end
      end else if (busy) begin
        if (cnt == P_CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        cnt <= cnt - P_CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fws_array_model.sv
module fws_array_model
  import fws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              otp,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= fws_word(addr, otp);
  end
endmodule

// File: rtl/flash_wait_ctrl.sv
module flash_wait_ctrl
  import fws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_otp,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata
);
  logic [RAND_W-1:0] rand_w;
  logic [PGW_W-1:0]  page_w;
  logic [OTPW_W-1:0] otp_w;
  logic              accept;
  logic              trk_hit;
  logic              trk_valid;
  logic              busy;
  logic [CNT_W-1:0]  sel_wait;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (req_otp)      sel_wait = CNT_W'(otp_w);
    else if (trk_hit) sel_wait = CNT_W'(page_w);
    else              sel_wait = CNT_W'(rand_w);
  end

  fws_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rand_w(rand_w), .page_w(page_w),
    .otp_w(otp_w), .cfg_rdata(cfg_rdata)
  );

  fws_page_track #(.P_ADDR_W(ADDR_W), .P_OFS_W(PAGE_OFS_W)) u_track (
    .clk(clk), .rst_n(rst_n), .accept(accept), .otp(req_otp),
    .addr(req_addr), .clear(cfg_wr), .hit(trk_hit), .valid(trk_valid)
  );

  fws_timer #(.P_CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .wait_n(sel_wait),
    .busy(busy), .done(rsp_valid)
  );

  fws_array_model u_array (
    .clk(clk), .rst_n(rst_n), .rd_en(accept), .otp(req_otp),
    .addr(req_addr), .rdata(rsp_data)
  );
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int P_CNT_W  = 5,
  parameter int P_OTPW_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_otp,
  input logic               rsp_valid,
  input logic               cfg_wr,
  input logic [P_CNT_W-1:0] sel_wait,
  input logic [P_OTPW_W-1:0] otp_w,
  input logic               trk_hit,
  input logic               trk_valid
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_RSP_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> req_ready); // R4
  AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n) (acc && sel_wait != '0) |=> (!req_ready && !rsp_valid)); // R4
  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (acc && sel_wait == '0) |=> (rsp_valid && req_ready)); // R5
  AST_OTP_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (acc && req_otp) |-> (sel_wait == P_CNT_W'(otp_w))); // R3
  AST_OTP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) req_otp |-> !trk_hit); // R3
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cfg_wr |=> !trk_valid); // R7
  AST_OTP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (acc && req_otp) |=> !trk_valid); // R7
endmodule

bind flash_wait_ctrl fws_checker #(.P_CNT_W(fws_pkg::CNT_W), .P_OTPW_W(fws_pkg::OTPW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_otp(req_otp), .rsp_valid(rsp_valid), .cfg_wr(cfg_wr),
  .sel_wait(sel_wait), .otp_w(otp_w), .trk_hit(trk_hit), .trk_valid(trk_valid)
);

// File: tb/tb_flash_wait_ctrl.sv
`timescale 1ns/1ps
module tb_flash_wait_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_otp = 1'b0;
  logic [11:0] req_addr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  // bench reference state
  int m_rand = 15, m_page = 15, m_otp = 31;
  int m_last = 0;
  bit m_valid = 1'b0;

  always #4 clk = ~clk;

  flash_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_otp(req_otp), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [11:0] a, input bit otp);
    logic [31:0] p;
    p = {20'd0, a} * 32'd40503;
    return p[15:0] ^ 16'h5A5A ^ (otp ? 16'hFFFF : 16'h0000);
  endfunction

  // reference wait selection; updates tracker model at acceptance
  function automatic int exp_wait(input logic [11:0] a, input bit otp);
    int n;
    if (otp) begin
      n = m_otp; m_valid = 1'b0;
    end else begin
      n = (m_valid && m_last == int'(a[11:7])) ? m_page : m_rand;
      m_last = int'(a[11:7]); m_valid = 1'b1;
    end
    return n;
  endfunction

  task automatic cfg_write(input bit sel, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!sel) begin m_rand = int'(d[3:0]); m_page = int'(d[11:8]); end
    else m_otp = int'(d[4:0]);
    m_valid = 1'b0;
  endtask

  // wait from just after an accepting edge until the response; returns latency
  task automatic wait_rsp(output int lat, output bit stalled_ok, input int n);
    lat = 1; stalled_ok = 1'b1;
    while (!rsp_valid && lat < 64) begin
      if (req_ready) stalled_ok = 1'b0;
      @(negedge clk); lat++;
    end
    if (n == 0 && !req_ready) stalled_ok = 1'b0;
  endtask

  task automatic do_single(input logic [11:0] a, input bit otp, input string req);
    int n, lat; bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_otp = otp;
    while (!req_ready) @(negedge clk);
    n = exp_wait(a, otp);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(lat, ok, n);
    check(lat == n + 1, {req, " R4 latency"}, lat, n + 1);
    check(ok && req_ready, {req, " R4 ready low only during stall"}, int'(ok), 1);
    check(rsp_data == exp_word(a, otp), {req, " R9 data"}, int'(rsp_data), int'(exp_word(a, otp)));
  endtask

  // second request held valid during the first stall (R8)
  task automatic do_pair(input logic [11:0] a1, input bit o1, input logic [11:0] a2, input bit o2);
    int n1, n2, lat; bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a1; req_otp = o1;
    while (!req_ready) @(negedge clk);
    n1 = exp_wait(a1, o1);
    @(negedge clk);
    req_addr = a2; req_otp = o2;
    wait_rsp(lat, ok, n1);
    check(lat == n1 + 1 && ok, "R8 first of pair latency", lat, n1 + 1);
    check(rsp_data == exp_word(a1, o1), "R9 first of pair data", int'(rsp_data), int'(exp_word(a1, o1)));
    n2 = exp_wait(a2, o2);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(lat, ok, n2);
    check(lat == n2 + 1 && ok, "R8 held request latency", lat, n2 + 1);
    check(rsp_data == exp_word(a2, o2), "R9 held request data", int'(rsp_data), int'(exp_word(a2, o2)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat, n; bit ok;
    int seed;
    seed = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    cfg_sel = 1'b0; #1;
    check(cfg_rdata == 16'h0F0F, "R1 bank reset", int'(cfg_rdata), 16'h0F0F);
    cfg_sel = 1'b1; #1;
    check(cfg_rdata == 16'h001F, "R1 otp reset", int'(cfg_rdata), 16'h001F);
    check(req_ready && !rsp_valid, "R1 idle after reset", int'({req_ready, rsp_valid}), 2);
    // R7 first read after reset is random (max 15)
    do_single(12'h105, 1'b0, "R7 post-reset random");
    // R2 reserved bits
    cfg_write(1'b0, 16'hFFFF);
    cfg_sel = 1'b0; #1;
    check(cfg_rdata == 16'h0F0F, "R2 bank reserved zero", int'(cfg_rdata), 16'h0F0F);
    cfg_write(1'b1, 16'hFFFF);
    cfg_sel = 1'b1; #1;
    check(cfg_rdata == 16'h001F, "R2 otp reserved zero", int'(cfg_rdata), 16'h001F);
    cfg_write(1'b0, 16'h0502);
    cfg_sel = 1'b0; #1;
    check(cfg_rdata == 16'h0502, "R2 bank fields", int'(cfg_rdata), 16'h0502);
    // typical values page=5 random=5 otp=8, then distinct page/random
    cfg_write(1'b0, 16'h0505);
    cfg_write(1'b1, 16'h0008);
    do_single(12'h200, 1'b0, "R6 random");
    do_single(12'h27F, 1'b0, "R6 page hit");
    cfg_write(1'b0, 16'h0207);
    do_single(12'h300, 1'b0, "R6 random after write");
    do_single(12'h301, 1'b0, "R6 page hit short");
    do_single(12'h381, 1'b0, "R6 page change");
    // R3 OTP at tracked page, R7 clears tracker
    do_single(12'h381, 1'b1, "R3 otp on tracked page");
    do_single(12'h381, 1'b0, "R7 flash after otp is random");
    // R5 zero waits
    cfg_write(1'b0, 16'h0000);
    cfg_write(1'b1, 16'h0000);
    do_single(12'h010, 1'b0, "R5 zero random");
    do_single(12'h011, 1'b0, "R5 zero page");
    do_single(12'h011, 1'b1, "R5 zero otp");
    do_pair(12'h012, 1'b0, 12'h013, 1'b0);
    // R10 write coinciding with acceptance
    cfg_write(1'b0, 16'h0106);
    do_single(12'h440, 1'b0, "R10 setup");
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0903;
    req_valid = 1'b1; req_addr = 12'h441; req_otp = 1'b0;
    n = exp_wait(12'h441, 1'b0);
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    m_rand = 3; m_page = 9; m_valid = 1'b0;
    wait_rsp(lat, ok, n);
    check(lat == 2 && ok, "R10 old page count used", lat, 2);
    do_single(12'h442, 1'b0, "R10 tracker cleared");
    // constrained random mix
    for (int i = 0; i < 160; i++) begin
      int op;
      logic [11:0] a, b;
      op = int'($urandom_range(0, 9));
      a = {2'b00, 3'($urandom_range(0, 3)), 7'($urandom)};
      b = {2'b00, 3'($urandom_range(0, 3)), 7'($urandom)};
      if (op < 5) do_single(a, 1'b0, "R6 random mix");
      else if (op < 7) do_pair(a, 1'($urandom_range(0, 1)), b, 1'($urandom_range(0, 1)));
      else if (op < 8) cfg_write(1'($urandom_range(0, 1)), 16'($urandom));
      else do_single(a, 1'b1, "R3 random otp");
    end
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule